// File: doc/BRIEF.md
# Aligned Power-of-Two Range Splitter

This block takes a memory region described by a start address and a byte length and cuts it into a run of segments. Each segment has a power-of-two size and a base that is a multiple of that size, so one base/mask pair can describe it in a range-matching register. Software or a configuration engine pulses `start` with the region. It then takes the segments one at a time over a valid/ready handshake and uses each base and mask to program a range-matching entry.

The split is greedy and follows the current address. At every step the block picks the largest power of two that divides the current address and still fits in the bytes left to cover. The order and the sizes of the segments therefore depend on how the start address is aligned. An aligned start yields large segments first. A misaligned start yields small segments that grow as the address becomes better aligned. The granularity is one 4 KiB page. After the last segment the block pulses `done`, and it reports the number of segments it produced together with two error flags: one for an illegal length and one for running past the segment limit.

Top module: `range_splitter`

## Requirements
- R1: Every segment presented on `segValid` has a size that is a power of two and at least 4096 bytes, and its base is a multiple of that size.
- R2: `segMask` has ones in every address bit at or above log2(`segSize`) and zeros below it. For example, an 8 KiB segment in a 32-bit space has mask 0xFFFFE000.
- R3: Each segment's size is the smaller of two values: the largest power of two that divides the current address, and the largest power of two not above the remaining length. A current address of zero places no limit from the address side. Segments are contiguous, start at the region start and cover the length exactly. A 56 KiB region at 0xA8642000 gives 8 KiB, 16 KiB, 32 KiB in that order. The same region at 0xE0000000 gives 32 KiB, 16 KiB, 8 KiB.
- R4: Bits 11:0 of `startAddr` are ignored. The first base is `startAddr` with those bits cleared.
- R5: A segment stays on the outputs, with `segValid` high and its fields stable, until a cycle in which `segReady` is high. Each such cycle takes exactly one segment, and the next segment appears in the following cycle.
- R6: If `regionSize` is zero or has any of bits 11:0 set when `start` is accepted, `errSize` and `done` are high in the next cycle, no segment is presented, and `segCount` reads 0.
- R7: `segCount` never exceeds MAX_SEGS (default 8). Suppose MAX_SEGS segments have been taken and some length is still uncovered. Then `errOverflow` and `done` go high in the cycle after the last handshake, and no further segment is presented.
- R8: On success, `done` rises in the cycle after the handshake of the final segment, with both error flags low. `done` is high for exactly one cycle. `segCount` and both error flags keep their values until the next accepted `start`.
- R9: A `start` pulse that arrives while segments are still pending has no effect on the segments being produced.
- R10: After reset, `segValid`, `done`, `errSize` and `errOverflow` are low and `segCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launches a job when the block is idle |
| startAddr | input | ADDR_W | Region start address; bits 11:0 ignored |
| regionSize | input | ADDR_W | Region length in bytes; must be a nonzero multiple of 4096 |
| segValid | output | 1 | A segment is presented |
| segReady | input | 1 | Consumer takes the presented segment |
| segBase | output | ADDR_W | Segment base address |
| segMask | output | ADDR_W | Segment address mask |
| segSize | output | ADDR_W | Segment size in bytes |
| done | output | 1 | One-cycle pulse when the job ends |
| segCount | output | $clog2(MAX_SEGS+1) | Number of segments taken in the current or last job |
| errSize | output | 1 | Last job had an illegal length |
| errOverflow | output | 1 | Last job needed more than MAX_SEGS segments |

## Verification
The bench builds the block with its defaults, ADDR_W = 32 and MAX_SEGS = 8. With a full 32-bit space, both 56 KiB example regions can be run with their exact addresses, and masks can be compared against the stated constant. A limit of 8 is small enough to reach in two ways. A 1 MiB region starting at page 1 needs nine segments, while a region one page shorter needs exactly eight, so the overflow boundary is hit from both sides. Random regions at random page alignments, with random back-pressure on `segReady`, exercise both the growing and the shrinking segment orders.

// File: rtl/splitter_pkg.sv
package splitter_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new region
    logic advance;  // current segment was taken
  } dpStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_EMIT = 1'b1
  } splitState_t;

endpackage

// File: rtl/splitter_datapath.sv
module splitter_datapath
  import splitter_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] regionSize,
  output logic [ADDR_W-1:0] segBase,
  output logic [ADDR_W-1:0] segMask,
  output logic [ADDR_W-1:0] segSize,
  output logic              lastSeg,
  output logic              sizeBad
);

  localparam int PW = ADDR_W - PAGE_BITS;

  logic [PW-1:0] curPage;
  logic [PW-1:0] remPages;
  logic [PW-1:0] addrLimit;
  logic [PW-1:0] remLimit;
  logic [PW-1:0] segPages;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPage  <= '0;
      remPages <= '0;
    end else if (strobe.load) begin
      curPage  <= startAddr[ADDR_W-1:PAGE_BITS];
      remPages <= regionSize[ADDR_W-1:PAGE_BITS];
    end else if (strobe.advance) begin
      curPage  <= curPage + segPages;
      remPages <= remPages - segPages;
    end
  end

  // lowest set bit of the address: the alignment it offers (zero = any)
  assign addrLimit = curPage & (~curPage + PW'(1));

  // highest set bit of the remaining length
  always_comb begin
    remLimit = '0;
    for (int i = 0; i < PW; i++) begin
      if (remPages[i]) begin
        remLimit    = '0;
        remLimit[i] = 1'b1;
      end
    end
  end

  assign segPages = ((addrLimit == '0) || (remLimit < addrLimit)) ? remLimit : addrLimit;

  assign segBase = {curPage, {PAGE_BITS{1'b0}}};
  assign segSize = {segPages, {PAGE_BITS{1'b0}}};
  assign segMask = ~(segSize - ADDR_W'(1));
  assign lastSeg = (remPages == segPages);
  assign sizeBad = (regionSize == '0) || (regionSize[PAGE_BITS-1:0] != '0);

endmodule

// File: rtl/splitter_control.sv
module splitter_control
  import splitter_pkg::*;
#(
  parameter int MAX_SEGS = 8,
  localparam int CNT_W   = $clog2(MAX_SEGS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             segReady,
  input  logic             sizeBad,
  input  logic             lastSeg,
  output dpStrobe_t        strobe,
  output logic             segValid,
  output logic             done,
  output logic [CNT_W-1:0] segCount,
  output logic             errSize,
  output logic             errOverflow
);

  splitState_t state;
  logic        take;
  logic        atLimit;

  assign segValid       = (state == ST_EMIT);
  assign take           = segValid && segReady;
  assign atLimit        = (segCount == CNT_W'(MAX_SEGS - 1));
  assign strobe.load    = (state == ST_IDLE) && start;
  assign strobe.advance = take;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      done        <= 1'b0;
      segCount    <= '0;
      errSize     <= 1'b0;
      errOverflow <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            segCount    <= '0;
            errSize     <= sizeBad;
            errOverflow <= 1'b0;
            if (sizeBad) done  <= 1'b1;
            else         state <= ST_EMIT;
          end
        end
        ST_EMIT: begin
          if (take) begin
            segCount <= segCount + CNT_W'(1);
            if (lastSeg) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else if (atLimit) begin
              errOverflow <= 1'b1;
              done        <= 1'b1;
              state       <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/range_splitter.sv
module range_splitter
  import splitter_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAX_SEGS = 8,
  localparam int CNT_W   = $clog2(MAX_SEGS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] regionSize,
  output logic              segValid,
  input  logic              segReady,
  output logic [ADDR_W-1:0] segBase,
  output logic [ADDR_W-1:0] segMask,
  output logic [ADDR_W-1:0] segSize,
  output logic              done,
  output logic [CNT_W-1:0]  segCount,
  output logic              errSize,
  output logic              errOverflow
);

  localparam int PAGE_BITS = 12;

  dpStrobe_t strobe;
  logic      lastSeg;
  logic      sizeBad;

  splitter_control #(.MAX_SEGS(MAX_SEGS)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .segReady(segReady),
    .sizeBad(sizeBad), .lastSeg(lastSeg), .strobe(strobe),
    .segValid(segValid), .done(done), .segCount(segCount),
    .errSize(errSize), .errOverflow(errOverflow)
  );

  splitter_datapath #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .regionSize(regionSize), .segBase(segBase), .segMask(segMask),
    .segSize(segSize), .lastSeg(lastSeg), .sizeBad(sizeBad)
  );

endmodule

// File: rtl/range_splitter_sva.sv
module range_splitter_sva #(
  parameter int ADDR_W   = 32,
  parameter int MAX_SEGS = 8,
  localparam int CNT_W   = $clog2(MAX_SEGS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              segValid,
  input logic              segReady,
  input logic [ADDR_W-1:0] segBase,
  input logic [ADDR_W-1:0] segMask,
  input logic [ADDR_W-1:0] segSize,
  input logic              done,
  input logic [CNT_W-1:0]  segCount,
  input logic              errSize
);

  AST_SEG_POW2: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> ($countones(segSize) == 1) && (segSize >= ADDR_W'(4096))); // R1
  AST_SEG_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> ((segBase & (segSize - ADDR_W'(1))) == '0)); // R1
  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    segValid |-> (ADDR_W'(segMask + segSize) == '0) && ((segBase & segMask) == segBase)); // R2
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (segValid && !segReady) |=> segValid && $stable(segBase) && $stable(segSize)); // R5
  AST_ERR_NO_SEG: assert property (@(posedge clk) disable iff (!rstN)
    errSize |-> !segValid); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    segCount <= CNT_W'(MAX_SEGS)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !segValid); // R8

endmodule

bind range_splitter range_splitter_sva #(.ADDR_W(ADDR_W), .MAX_SEGS(MAX_SEGS)) uSva (
  .clk(clk), .rstN(rstN), .segValid(segValid), .segReady(segReady),
  .segBase(segBase), .segMask(segMask), .segSize(segSize), .done(done),
  .segCount(segCount), .errSize(errSize)
);

// File: tb/range_splitter_test.sv
module range_splitter_test;

  localparam int AW    = 32;
  localparam int MAXS  = 8;
  localparam int CW    = $clog2(MAXS + 1);
  localparam int PW    = AW - 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [AW-1:0] regionSize = '0;
  logic          segReady = 1'b0;
  logic          segValid, done, errSize, errOverflow;
  logic [AW-1:0] segBase, segMask, segSize;
  logic [CW-1:0] segCount;

  int nChecks = 0;
  int nFails  = 0;
  longint cycles = 0;

  logic [AW-1:0] expBase [16];
  logic [AW-1:0] expSize [16];
  int            expN;
  bit            expErrS, expErrO;

  always #2 clk = ~clk;

  range_splitter #(.ADDR_W(AW), .MAX_SEGS(MAXS)) uut (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr),
    .regionSize(regionSize), .segValid(segValid), .segReady(segReady),
    .segBase(segBase), .segMask(segMask), .segSize(segSize), .done(done),
    .segCount(segCount), .errSize(errSize), .errOverflow(errOverflow)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference: greedy split by pages
  task automatic model(input logic [AW-1:0] addr, input logic [AW-1:0] size);
    bit [PW:0] pa, rem, lowA, highR, seg;
    expN = 0; expErrO = 0;
    expErrS = (size == 0) || (size[11:0] != 0);
    if (expErrS) return;
    pa  = {1'b0, addr[AW-1:12]};
    rem = {1'b0, size[AW-1:12]};
    while (rem != 0) begin
      if (expN == MAXS) begin expErrO = 1; break; end
      lowA = (pa == 0) ? (1 << PW) : (pa & -pa);
      highR = 1;
      while ((highR << 1) <= rem) highR = highR << 1;
      seg = (highR < lowA) ? highR : lowA;
      expBase[expN] = {pa[PW-1:0], 12'h000};
      expSize[expN] = {seg[PW-1:0], 12'h000};
      expN++;
      pa  = (pa + seg) & ((1 << PW) - 1);
      rem = rem - seg;
    end
  endtask

  task automatic runJob(input logic [AW-1:0] addr, input logic [AW-1:0] size,
                        input int readyPct, input bit poke, input string tag);
    int k = 0;
    int cyc = 0;
    bit doneSeen = 0;
    bit lastTook = 0;
    bit poked = 0;
    model(addr, size);
    @(negedge clk);
    start = 1; startAddr = addr; regionSize = size; segReady = 0;
    @(negedge clk);
    start = 0;
    while (!doneSeen && cyc < 4000) begin
      bit take;
      start = 0; segReady = 0; take = 0;
      if (done) begin
        doneSeen = 1;
        check(k == expN, {tag, " R8 segments taken before done"}, k, expN);
        check(segCount == CW'(expN), {tag, " R7 segCount"}, segCount, expN);
        check(errSize == expErrS, {tag, " R6 errSize"}, errSize, expErrS);
        check(errOverflow == expErrO, {tag, " R7 errOverflow"}, errOverflow, expErrO);
        if (expErrS) check(cyc == 0, {tag, " R6 done latency"}, cyc, 0);
        else         check(lastTook, {tag, " R8 done right after last handshake"}, lastTook, 1);
      end else if (segValid) begin
        if (k >= expN) begin
          check(0, {tag, " R3 extra segment"}, segBase, 0);
          doneSeen = 1;
        end else begin
          check(segBase == expBase[k], {tag, " R3 base"}, segBase, expBase[k]);
          check(segSize == expSize[k], {tag, " R3 size"}, segSize, expSize[k]);
          check(segMask == ~(expSize[k] - 1), {tag, " R2 mask"}, segMask, ~(expSize[k] - 1));
          take = ($urandom % 100) < readyPct;
          segReady = take;
          if (poke && !poked && k == 1) begin
            start = 1; startAddr = 32'h0; regionSize = 32'h1000; poked = 1;  // R9
          end
        end
      end else begin
        check(0, {tag, " R5 neither valid nor done"}, 0, 1);
        doneSeen = 1;
      end
      @(negedge clk);
      lastTook = take;
      if (take) k++;
      cyc++;
    end
    start = 0; segReady = 0;
    check(doneSeen, {tag, " R8 job finished"}, doneSeen, 1);
    check(!done, {tag, " R8 done one cycle"}, done, 0);
    check(segCount == CW'(expN) && errSize == expErrS && errOverflow == expErrO,
          {tag, " R8 results held"}, segCount, expN);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nFails++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
        $finish;
      end
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(!segValid && !done && !errSize && !errOverflow && segCount == 0,
          "R10 reset state", {segValid, done, errSize, errOverflow}, 0);
    rstN = 1;
    @(negedge clk);
    check(!segValid && !done && segCount == 0, "R10 idle after reset", segValid, 0);

    runJob(32'hA864_2000, 32'h0000_E000, 100, 0, "R3 misaligned 56K");
    runJob(32'hE000_0000, 32'h0000_E000, 50, 0, "R3 aligned 56K");
    runJob(32'hA864_2ABC, 32'h0000_E000, 70, 0, "R4 low address bits");
    runJob(32'h0000_0000, 32'h0010_0000, 40, 0, "R1 zero base 1M");
    runJob(32'h1234_5000, 32'h0000_0000, 100, 0, "R6 zero size");
    runJob(32'h1234_5000, 32'h0000_1800, 100, 0, "R6 unaligned size");
    runJob(32'h1234_5000, 32'h0000_0FFF, 100, 0, "R6 sub-page size");
    runJob(32'h0000_1000, 32'h000F_F000, 80, 0, "R7 exactly limit");
    runJob(32'h0000_1000, 32'h0010_0000, 80, 0, "R7 one over limit");
    runJob(32'h0000_3000, 32'h0000_5000, 30, 1, "R9 start while busy");
    runJob(32'hFFFF_F000, 32'h0000_1000, 100, 0, "R1 top page");
    runJob(32'h0800_0000, 32'h0800_0000, 20, 0, "R5 backpressure single");

    for (int j = 0; j < 60; j++) begin
      logic [AW-1:0] a, s;
      int sh = $urandom % 20;
      a = ($urandom & ~((32'h1 << sh) - 1)) & 32'hFFFF_F000;
      if ($urandom % 8 == 0) a = a | ($urandom & 32'hFFF);
      if ($urandom % 10 == 0) s = $urandom % 32'h3000;
      else s = ((($urandom % 400) + 1) << 12);
      runJob(a, s, 30 + ($urandom % 71), ($urandom % 6 == 0), "R3 random");
    end

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule